// File: doc/BRIEF.md
# Toggle-Coded Busy Receiver and Combiner

This block moves a busy flag across AC-coupled differential pairs, which cannot carry a static level. A sender shows "busy" by driving a running clock on the pair and shows "not busy" by releasing it. When released, the far receiver settles to whatever idle level its own design gives.

Each of the block's downstream ports samples one such line in the local clock domain. The line passes through a two-flop synchroniser. An optional per-port inversion brings the receiver's idle default to a known logic level. Rising edges of the corrected line are then counted in fixed windows to recover a busy level.

The recovered busy flags of all downstream ports are masked by a registered per-port enable and ORed. The result is sent upstream with the same coding: the upstream line toggles at one quarter of the system clock, and its output enable is asserted only while the combined busy is high. The far end uses the upstream busy to halt data taking.

Top module: `busy_link_hub`

## Requirements
- R1: After synchronous reset, every output is 0: per-port busy, per-port level, combined busy, upstream line and upstream output enable.
- R2: A port reports busy once at least 3 rising edges of its corrected line fall inside one 32-cycle counting window. A line toggling with a 4-cycle period therefore shows busy within 40 cycles, whatever the port's inversion bit.
- R3: A port that sees fewer than 3 rising edges and then a quiet line never reports busy.
- R4: A busy port clears its flag after 64 consecutive cycles with no rising edge. It is still busy 40 cycles after the line goes quiet and is clear 90 cycles after.
- R5: The per-port level output equals the sampled line XOR the port's inversion bit (1 = invert). It passes through two synchroniser flops and one output register.
- R6: A line held at a static level, high or low, never produces busy, with or without inversion.
- R7: The combined busy is the OR of the per-port busy flags ANDed with the enable bits (1 = port counted). Both the enable bits and the combined busy are registered.
- R8: A port whose enable bit is 0 still reports its own busy, but it cannot raise the combined busy or the upstream output enable.
- R9: While enabled, the upstream line repeats a 4-cycle pattern of two low and two high cycles, so it is high in exactly 8 of any 16 consecutive cycles. While not enabled, it is held low.
- R10: The upstream output enable follows the combined busy one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | NPORTS | Sampled downstream busy lines, asynchronous |
| inv_i | input | NPORTS | Per-port inversion bit, 1 = invert the line |
| port_en_i | input | NPORTS | Per-port enable bit, 1 = port counted in the combined busy |
| busy_o | output | NPORTS | Recovered busy flag per port |
| lvl_o | output | NPORTS | Synchronised, polarity-corrected line level per port |
| up_busy_o | output | 1 | Combined busy |
| up_line_o | output | 1 | Upstream toggle-coded busy line |
| up_oe_o | output | 1 | Upstream line output enable |

## Verification
If a port's edge or window counter is wrong, the fault appears on that port's busy flag within about 40 cycles of a toggle starting. It can also appear as a false busy from static or sparse edges. A wrong quiet counter shows up as a flag that drops too early or lingers past about 70 cycles. Errors in the mask or OR appear on the combined busy two cycles after the cause. Divider errors break the 8-of-16 high count on the upstream line at once.

// File: rtl/busy_link_pkg.sv
package busy_link_pkg;
  // Modular increment used by the window and divider counters.
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned lim);
    return (v >= lim - 1) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/busy_line_rx.sv
module busy_line_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int WIN_LEN     = 32,
  parameter int EDGE_MIN    = 3,
  parameter int QUIET_LEN   = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  input  logic inv_i,
  output logic busy_o,
  output logic lvl_o
);
  import busy_link_pkg::*;
  localparam int WW = $clog2(WIN_LEN);
  localparam int EW = $clog2(EDGE_MIN + 1);
  localparam int QW = $clog2(QUIET_LEN);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   cur_q, prev_q;
  logic [WW-1:0]          win_q;
  logic [EW-1:0]          ecnt_q;
  logic [QW-1:0]          quiet_q;
  logic                   rise;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= 1'b0;
      prev_q <= 1'b0;
      lvl_o  <= 1'b0;
    end else begin
      cur_q  <= sync_q[SYNC_STAGES-1] ^ inv_i;
      prev_q <= cur_q;
      lvl_o  <= sync_q[SYNC_STAGES-1] ^ inv_i;
    end
  end

  assign rise = cur_q & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q   <= '0;
      ecnt_q  <= '0;
      quiet_q <= '0;
      busy_o  <= 1'b0;
    end else begin
      win_q <= WW'(wrap_inc(int'(win_q), WIN_LEN));
      if (win_q == WW'(WIN_LEN - 1))
        ecnt_q <= rise ? EW'(1) : '0;
      else if (rise && ecnt_q != EW'(EDGE_MIN))
        ecnt_q <= ecnt_q + EW'(1);

      if (rise) quiet_q <= '0;
      else if (quiet_q != QW'(QUIET_LEN - 1)) quiet_q <= quiet_q + QW'(1);

      if (rise && ecnt_q >= EW'(EDGE_MIN - 1) && win_q != WW'(WIN_LEN - 1))
        busy_o <= 1'b1;
      else if (!rise && quiet_q == QW'(QUIET_LEN - 1))
        busy_o <= 1'b0;
    end
  end
endmodule

// File: rtl/busy_line_tx.sv
module busy_line_tx #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic busy_i,
  output logic line_o,
  output logic oe_o
);
  import busy_link_pkg::*;
  localparam int DW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;

  logic [DW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      line_o <= 1'b0;
      oe_o   <= 1'b0;
    end else begin
      div_q  <= busy_i ? DW'(wrap_inc(int'(div_q), DIV)) : '0;
      line_o <= busy_i && (div_q >= DW'(HALF));
      oe_o   <= busy_i;
    end
  end
endmodule

// File: rtl/busy_link_hub.sv
module busy_link_hub #(
  parameter int NPORTS      = 10,
  parameter int SYNC_STAGES = 2,
  parameter int WIN_LEN     = 32,
  parameter int EDGE_MIN    = 3,
  parameter int QUIET_LEN   = 64,
  parameter int DIV         = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPORTS-1:0] line_i,
  input  logic [NPORTS-1:0] inv_i,
  input  logic [NPORTS-1:0] port_en_i,
  output logic [NPORTS-1:0] busy_o,
  output logic [NPORTS-1:0] lvl_o,
  output logic              up_busy_o,
  output logic              up_line_o,
  output logic              up_oe_o
);
  logic [NPORTS-1:0] en_q;

  for (genvar g = 0; g < NPORTS; g++) begin : g_rx
    busy_line_rx #(
      .SYNC_STAGES(SYNC_STAGES), .WIN_LEN(WIN_LEN),
      .EDGE_MIN(EDGE_MIN), .QUIET_LEN(QUIET_LEN)
    ) u_rx (
      .clk(clk), .rst(rst), .line_i(line_i[g]), .inv_i(inv_i[g]),
      .busy_o(busy_o[g]), .lvl_o(lvl_o[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= '0;
      up_busy_o <= 1'b0;
    end else begin
      en_q      <= port_en_i;
      up_busy_o <= |(busy_o & en_q);
    end
  end

  busy_line_tx #(.DIV(DIV)) u_tx (
    .clk(clk), .rst(rst), .busy_i(up_busy_o),
    .line_o(up_line_o), .oe_o(up_oe_o)
  );
endmodule

// File: rtl/busy_link_chk.sv
module busy_link_chk #(
  parameter int NPORTS = 10
) (
  input logic              clk,
  input logic              rst,
  input logic [NPORTS-1:0] busy_o,
  input logic [NPORTS-1:0] en_q,
  input logic              up_busy_o,
  input logic              up_line_o,
  input logic              up_oe_o
);
  p_combine_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> up_busy_o == $past(|(busy_o & en_q)));

  p_oe_follows_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> up_oe_o == $past(up_busy_o));

  p_line_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !up_oe_o |-> !up_line_o);

  p_toggle_period_r9: assert property (@(posedge clk) disable iff (rst)
    (up_oe_o && $past(up_oe_o) && $past(up_oe_o, 2) && $past(up_oe_o, 3))
      |-> up_line_o != $past(up_line_o, 2));

  p_masked_no_up_r8: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |=> !up_busy_o);
endmodule

bind busy_link_hub busy_link_chk #(.NPORTS(NPORTS)) u_chk (
  .clk(clk), .rst(rst), .busy_o(busy_o), .en_q(en_q),
  .up_busy_o(up_busy_o), .up_line_o(up_line_o), .up_oe_o(up_oe_o)
);

// File: tb/sim_busy_link_hub.sv
`timescale 1ns/1ps
module sim_busy_link_hub;
  localparam int N = 10;
  logic clk = 1'b0, rst = 1'b1;
  logic [N-1:0] line_i, inv_i, port_en_i, busy_o, lvl_o;
  logic up_busy_o, up_line_o, up_oe_o;
  logic [N-1:0] tog = '0, stat = '0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  busy_link_hub u0 (.clk(clk), .rst(rst), .line_i(line_i), .inv_i(inv_i),
    .port_en_i(port_en_i), .busy_o(busy_o), .lvl_o(lvl_o),
    .up_busy_o(up_busy_o), .up_line_o(up_line_o), .up_oe_o(up_oe_o));

  // Line driver: toggling ports run with a 4-cycle period, others hold stat.
  initial begin
    logic [1:0] ph = '0;
    line_i = '0;
    forever begin
      @(negedge clk);
      ph = ph + 2'd1;
      for (int i = 0; i < N; i++) line_i[i] = tog[i] ? ph[1] : stat[i];
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset;
    chk("R1 busy", busy_o, 0); chk("R1 lvl", lvl_o, 0);
    chk("R1 up_busy", up_busy_o, 0); chk("R1 up_line", up_line_o, 0);
    chk("R1 up_oe", up_oe_o, 0);
  endtask

  task automatic t_level_static;
    stat[3] = 1'b1; tick(6);
    chk("R5 lvl plain", lvl_o[3], 1);
    inv_i[3] = 1'b1; tick(3);
    chk("R5 lvl inverted", lvl_o[3], 0);
    tick(100);
    chk("R6 static high no busy", busy_o[3], 0);
    stat[3] = 1'b0; tick(100);
    chk("R6 static low no busy", busy_o[3], 0);
    inv_i[3] = 1'b0;
  endtask

  task automatic t_set_and_tx;
    int hi = 0;
    tog[0] = 1'b1; tick(40);
    chk("R2 busy from toggle", busy_o[0], 1);
    chk("R7 combined busy", up_busy_o, 1);
    chk("R10 oe on", up_oe_o, 1);
    for (int k = 0; k < 16; k++) begin
      hi += int'(up_line_o);
      tick(1);
    end
    chk("R9 upstream high count", hi, 8);
  endtask

  task automatic t_clear;
    tog[0] = 1'b0; tick(40);
    chk("R4 still busy at 40 quiet", busy_o[0], 1);
    tick(50);
    chk("R4 cleared at 90 quiet", busy_o[0], 0);
    chk("R7 combined clear", up_busy_o, 0);
    chk("R10 oe off", up_oe_o, 0);
    chk("R9 line low idle", up_line_o, 0);
  endtask

  task automatic t_sparse;
    stat[1] = 1'b1; tick(4); stat[1] = 1'b0; tick(6);
    stat[1] = 1'b1; tick(4); stat[1] = 1'b0; tick(100);
    chk("R3 two edges no busy", busy_o[1], 0);
  endtask

  task automatic t_inverted_toggle;
    inv_i[4] = 1'b1; tog[4] = 1'b1; tick(40);
    chk("R2 busy with inversion", busy_o[4], 1);
    tog[4] = 1'b0; tick(100);
    chk("R4 inverted port clears", busy_o[4], 0);
  endtask

  task automatic t_mask;
    port_en_i = ~(N'(1) << 2);
    tick(3);
    tog[2] = 1'b1; tick(40);
    chk("R8 port busy reported", busy_o[2], 1);
    chk("R8 masked no combined", up_busy_o, 0);
    chk("R8 masked no oe", up_oe_o, 0);
    port_en_i = '1; tick(4);
    chk("R7 enabled port raises combined", up_busy_o, 1);
    tog[2] = 1'b0; tick(100);
  endtask

  initial begin
    inv_i = '0; port_en_i = '1;
    tick(5); rst = 1'b0; tick(1);
    t_reset();
    t_level_static();
    t_set_and_tx();
    t_clear();
    t_sparse();
    t_inverted_toggle();
    t_mask();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule